// File: doc/BRIEF.md
# Address-Event Fan-Out Router

This block carries neuron spike traffic as address words instead of single-bit pulses. A neuron whose state changed sends its own address. The router folds that address into a source index, then looks up a host-written fan-out table. The table holds a start index and a target count for each source. The router walks the listed targets one per clock. Each target word holds a destination neuron address, a destination chip number and a delay counted in time slots.

Targets on this chip are placed into one of a ring of per-slot queues, chosen as the current slot plus the delay. When the slot counter reaches that slot, the queue drains onto a valid/ready broadcast stream, in the order the items arrived. Targets on another chip go out immediately on a remote stream. The remote stream carries the full address, the chip number and the slot offset. Only a slow host port writes the tables, and rewriting an entry rewires which targets a source drives. The neuron arithmetic, reconfiguration and inter-chip link are outside this block.

Top module: `aer_fanout_router`

## Requirements
- R1: After reset the slot counter is 0, `outValid` and `remValid` are low, `evReady` is high, both sticky flags are clear, and every source has a target count of zero.
- R2: An accepted event selects the source index formed by XOR-ing together all 4-bit slices of `evAddr`. Its targets are visited at indices start to start+count-1, one per clock. `evReady` stays low while the visit runs. A source whose count is zero produces no output.
- R3: A target whose chip field equals `LOCAL_CHIP` (default 0) is local. Any other chip value makes it remote.
- R4: A local target with delay d, met while the slot counter is s, is queued for slot (s+d) mod `NUM_SLOTS`. It is not emitted before the counter reaches that slot. A delay of 0 means the current slot.
- R5: The slot counter advances by one on each `slotTick`. It wraps from `NUM_SLOTS`-1 (149) to 0 and holds otherwise.
- R6: The queue of the current slot drains onto `outValid`/`outReady` in arrival order. `outAddr` carries the low `LOC_W` (24) bits of the target address.
- R7: A remote target with a non-zero delay raises `remValid` with the full address, chip and delay. These stay stable, and the target walk stalls, until `remReady` is high.
- R8: A remote target with delay 0 is never forwarded. It sets the sticky `zeroDelayErr`, and the walk goes on to the next target.
- R9: A local target whose slot queue already holds `Q_DEPTH` (4) items is dropped and sets the sticky `overflowFlag`. The queued items are unaffected.
- R10: A host write to the source map or the target array changes the routing of every later event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Event address present |
| evReady | output | 1 | Router idle, event accepted |
| evAddr | input | ADDR_W | Address of the neuron that changed |
| slotTick | input | 1 | Advance to the next time slot |
| mapWrEn | input | 1 | Host write to the source map |
| mapIdx | input | log2(NUM_SRC) | Source index written |
| mapStart | input | log2(NUM_TGT) | First target index of the source |
| mapCount | input | log2(NUM_TGT+1) | Number of targets of the source |
| tgtWrEn | input | 1 | Host write to the target array |
| tgtIdx | input | log2(NUM_TGT) | Target index written |
| tgtAddr | input | ADDR_W | Destination neuron address |
| tgtChip | input | CHIP_W | Destination chip |
| tgtDelay | input | SLOT_W | Delay in slots |
| curSlot | output | SLOT_W | Slot being broadcast |
| outValid | output | 1 | Local broadcast item present |
| outReady | input | 1 | Local consumer takes item |
| outAddr | output | LOC_W | Local destination address |
| remValid | output | 1 | Remote item present |
| remReady | input | 1 | Remote link takes item |
| remAddr | output | ADDR_W | Remote destination address |
| remChip | output | CHIP_W | Remote destination chip |
| remDelay | output | SLOT_W | Slot offset for the remote chip |
| overflowFlag | output | 1 | Sticky: a local item was dropped |
| zeroDelayErr | output | 1 | Sticky: remote target had delay 0 |

## Verification
The push of a zero-delay local target and the pop of the broadcast output can hit the same slot queue in the same cycle. The bench provokes this with a source that lists three zero-delay targets back to back while `outReady` is held high, so each new item is written while the previous one leaves. A scoreboard judges the result by the exact order and count of the broadcast addresses. A stalled remote item is also checked against a waiting local target, which must not overtake it.

// File: rtl/aer_pkg.sv
package aer_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_EXPAND = 1'b1
  } ctlState_t;

  // strobes from the walk control to the datapath
  typedef struct packed {
    logic enq;       // queue current target locally
    logic fwd;       // offer current target remotely
    logic flagZero;  // remote target with zero delay
  } ctlStrobe_t;

  // classification of the target under the read index
  typedef struct packed {
    logic isLocal;
    logic zeroDelay;
  } tgtClass_t;

endpackage

// File: rtl/aer_ctrl.sv
module aer_ctrl
  import aer_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_TGT = 32,
  parameter int ADDR_W  = 32,
  localparam int SRC_IW = $clog2(NUM_SRC),
  localparam int TGT_IW = $clog2(NUM_TGT),
  localparam int CNT_W  = $clog2(NUM_TGT + 1),
  localparam int SLICES = ADDR_W / SRC_IW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic [ADDR_W-1:0] evAddr,
  output logic              evReady,
  input  logic              mapWrEn,
  input  logic [SRC_IW-1:0] mapIdx,
  input  logic [TGT_IW-1:0] mapStart,
  input  logic [CNT_W-1:0]  mapCount,
  input  tgtClass_t         cls,
  input  logic              remReady,
  output logic [TGT_IW-1:0] rdIdx,
  output ctlStrobe_t        stb
);

  ctlState_t         state;
  logic [CNT_W-1:0]  remain;
  logic [TGT_IW-1:0] startTab [NUM_SRC];
  logic [CNT_W-1:0]  cntTab   [NUM_SRC];
  logic [SRC_IW-1:0] srcIdx;
  logic              step;

  // fold the whole address word into a table index
  always_comb begin
    srcIdx = '0;
    for (int i = 0; i < SLICES; i++) srcIdx = srcIdx ^ evAddr[i*SRC_IW +: SRC_IW];
  end

  assign evReady = (state == ST_IDLE);

  always_comb begin
    stb = '0;
    if (state == ST_EXPAND) begin
      stb.enq      = cls.isLocal;
      stb.flagZero = !cls.isLocal && cls.zeroDelay;
      stb.fwd      = !cls.isLocal && !cls.zeroDelay;
    end
    step = stb.enq | stb.flagZero | (stb.fwd & remReady);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rdIdx  <= '0;
      remain <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        startTab[i] <= '0;
        cntTab[i]   <= '0;
      end
    end else begin
      if (mapWrEn) begin
        startTab[mapIdx] <= mapStart;
        cntTab[mapIdx]   <= mapCount;
      end
      case (state)
        ST_IDLE: begin
          if (evValid && cntTab[srcIdx] != '0) begin
            state  <= ST_EXPAND;
            rdIdx  <= startTab[srcIdx];
            remain <= cntTab[srcIdx];
          end
        end
        default: begin
          if (step) begin
            rdIdx  <= rdIdx + 1'b1;
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1)) state <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/aer_data.sv
module aer_data
  import aer_pkg::*;
#(
  parameter int NUM_TGT    = 32,
  parameter int NUM_SLOTS  = 150,
  parameter int Q_DEPTH    = 4,
  parameter int ADDR_W     = 32,
  parameter int LOC_W      = 24,
  parameter int CHIP_W     = 4,
  parameter int LOCAL_CHIP = 0,
  localparam int TGT_IW = $clog2(NUM_TGT),
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int QP_W   = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1,
  localparam int QC_W   = $clog2(Q_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tgtWrEn,
  input  logic [TGT_IW-1:0] tgtIdx,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [CHIP_W-1:0] tgtChip,
  input  logic [SLOT_W-1:0] tgtDelay,
  input  logic [TGT_IW-1:0] rdIdx,
  input  ctlStrobe_t        stb,
  output tgtClass_t         cls,
  input  logic              slotTick,
  output logic [SLOT_W-1:0] curSlot,
  output logic              outValid,
  input  logic              outReady,
  output logic [LOC_W-1:0]  outAddr,
  output logic [ADDR_W-1:0] remAddr,
  output logic [CHIP_W-1:0] remChip,
  output logic [SLOT_W-1:0] remDelay,
  output logic              overflowFlag,
  output logic              zeroDelayErr
);

  logic [ADDR_W-1:0] addrMem  [NUM_TGT];
  logic [CHIP_W-1:0] chipMem  [NUM_TGT];
  logic [SLOT_W-1:0] delayMem [NUM_TGT];

  always_ff @(posedge clk) begin
    if (tgtWrEn) begin
      addrMem[tgtIdx]  <= tgtAddr;
      chipMem[tgtIdx]  <= tgtChip;
      delayMem[tgtIdx] <= tgtDelay;
    end
  end

  assign remAddr       = addrMem[rdIdx];
  assign remChip       = chipMem[rdIdx];
  assign remDelay      = delayMem[rdIdx];
  assign cls.isLocal   = (remChip == CHIP_W'(LOCAL_CHIP));
  assign cls.zeroDelay = (remDelay == '0);

  // destination slot of a local target, modulo the ring length
  logic [SLOT_W:0]   slotSum;
  logic [SLOT_W-1:0] dstSlot;
  assign slotSum = {1'b0, curSlot} + {1'b0, remDelay};
  assign dstSlot = (slotSum >= (SLOT_W+1)'(NUM_SLOTS))
                 ? SLOT_W'(slotSum - (SLOT_W+1)'(NUM_SLOTS))
                 : slotSum[SLOT_W-1:0];

  logic             qFull [NUM_SLOTS];
  logic             qAny  [NUM_SLOTS];
  logic [LOC_W-1:0] qHead [NUM_SLOTS];
  logic             push, pop;

  assign push     = stb.enq && !qFull[dstSlot];
  assign outValid = qAny[curSlot];
  assign outAddr  = qHead[curSlot];
  assign pop      = outValid && outReady;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic [LOC_W-1:0] mem [Q_DEPTH];
    logic [QP_W-1:0]  wrPtr, rdPtr;
    logic [QC_W-1:0]  cnt;
    logic             pushG, popG;

    assign pushG    = push && (dstSlot == SLOT_W'(g));
    assign popG     = pop && (curSlot == SLOT_W'(g));
    assign qFull[g] = (cnt == QC_W'(Q_DEPTH));
    assign qAny[g]  = (cnt != '0);
    assign qHead[g] = mem[rdPtr];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (pushG) begin
          mem[wrPtr] <= remAddr[LOC_W-1:0];
          wrPtr      <= (wrPtr == QP_W'(Q_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        end
        if (popG) rdPtr <= (rdPtr == QP_W'(Q_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        cnt <= cnt + QC_W'(pushG) - QC_W'(popG);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSlot      <= '0;
      overflowFlag <= 1'b0;
      zeroDelayErr <= 1'b0;
    end else begin
      if (slotTick)
        curSlot <= (curSlot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : curSlot + 1'b1;
      if (stb.enq && qFull[dstSlot]) overflowFlag <= 1'b1;
      if (stb.flagZero) zeroDelayErr <= 1'b1;
    end
  end

endmodule

// File: rtl/aer_fanout_router.sv
module aer_fanout_router
  import aer_pkg::*;
#(
  parameter int NUM_SRC    = 16,
  parameter int NUM_TGT    = 32,
  parameter int NUM_SLOTS  = 150,
  parameter int Q_DEPTH    = 4,
  parameter int ADDR_W     = 32,
  parameter int LOC_W      = 24,
  parameter int CHIP_W     = 4,
  parameter int LOCAL_CHIP = 0,
  localparam int SRC_IW = $clog2(NUM_SRC),
  localparam int TGT_IW = $clog2(NUM_TGT),
  localparam int CNT_W  = $clog2(NUM_TGT + 1),
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  output logic              evReady,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic              slotTick,
  input  logic              mapWrEn,
  input  logic [SRC_IW-1:0] mapIdx,
  input  logic [TGT_IW-1:0] mapStart,
  input  logic [CNT_W-1:0]  mapCount,
  input  logic              tgtWrEn,
  input  logic [TGT_IW-1:0] tgtIdx,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [CHIP_W-1:0] tgtChip,
  input  logic [SLOT_W-1:0] tgtDelay,
  output logic [SLOT_W-1:0] curSlot,
  output logic              outValid,
  input  logic              outReady,
  output logic [LOC_W-1:0]  outAddr,
  output logic              remValid,
  input  logic              remReady,
  output logic [ADDR_W-1:0] remAddr,
  output logic [CHIP_W-1:0] remChip,
  output logic [SLOT_W-1:0] remDelay,
  output logic              overflowFlag,
  output logic              zeroDelayErr
);

  ctlStrobe_t        stb;
  tgtClass_t         cls;
  logic [TGT_IW-1:0] rdIdx;

  aer_ctrl #(
    .NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evAddr(evAddr), .evReady(evReady),
    .mapWrEn(mapWrEn), .mapIdx(mapIdx), .mapStart(mapStart), .mapCount(mapCount),
    .cls(cls), .remReady(remReady), .rdIdx(rdIdx), .stb(stb)
  );

  aer_data #(
    .NUM_TGT(NUM_TGT), .NUM_SLOTS(NUM_SLOTS), .Q_DEPTH(Q_DEPTH), .ADDR_W(ADDR_W),
    .LOC_W(LOC_W), .CHIP_W(CHIP_W), .LOCAL_CHIP(LOCAL_CHIP)
  ) uData (
    .clk(clk), .rstN(rstN), .tgtWrEn(tgtWrEn), .tgtIdx(tgtIdx), .tgtAddr(tgtAddr),
    .tgtChip(tgtChip), .tgtDelay(tgtDelay), .rdIdx(rdIdx), .stb(stb), .cls(cls),
    .slotTick(slotTick), .curSlot(curSlot), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .remAddr(remAddr), .remChip(remChip), .remDelay(remDelay),
    .overflowFlag(overflowFlag), .zeroDelayErr(zeroDelayErr)
  );

  assign remValid = stb.fwd;

endmodule

// File: rtl/aer_fanout_chk.sv
module aer_fanout_chk #(
  parameter int NUM_SLOTS = 150,
  parameter int ADDR_W    = 32,
  parameter int CHIP_W    = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              evReady,
  input logic              slotTick,
  input logic              tgtWrEn,
  input logic [SLOT_W-1:0] curSlot,
  input logic              remValid,
  input logic              remReady,
  input logic [ADDR_W-1:0] remAddr,
  input logic [CHIP_W-1:0] remChip,
  input logic [SLOT_W-1:0] remDelay,
  input logic              overflowFlag,
  input logic              zeroDelayErr
);

  // R7
  rem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    remValid && !remReady && !tgtWrEn |=> remValid && $stable(remAddr)
      && $stable(remChip) && $stable(remDelay));

  // R8
  rem_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    remValid |-> remDelay != '0);

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(curSlot) < NUM_SLOTS);

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotTick |=> int'(curSlot) ==
      ((int'($past(curSlot)) == NUM_SLOTS - 1) ? 0 : int'($past(curSlot)) + 1));

  // R5
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slotTick |=> $stable(curSlot));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  // R8
  zero_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroDelayErr |=> zeroDelayErr);

  // R2
  busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    remValid |-> !evReady);

endmodule

bind aer_fanout_router aer_fanout_chk #(
  .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .CHIP_W(CHIP_W)
) uChk (
  .clk(clk), .rstN(rstN), .evReady(evReady), .slotTick(slotTick), .tgtWrEn(tgtWrEn),
  .curSlot(curSlot), .remValid(remValid), .remReady(remReady), .remAddr(remAddr),
  .remChip(remChip), .remDelay(remDelay), .overflowFlag(overflowFlag),
  .zeroDelayErr(zeroDelayErr)
);

// File: tb/sim_aer_fanout_router.sv
module sim_aer_fanout_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0;
  logic        evReady;
  logic [31:0] evAddr = '0;
  logic        slotTick = 1'b0;
  logic        mapWrEn = 1'b0;
  logic [3:0]  mapIdx = '0;
  logic [4:0]  mapStart = '0;
  logic [5:0]  mapCount = '0;
  logic        tgtWrEn = 1'b0;
  logic [4:0]  tgtIdx = '0;
  logic [31:0] tgtAddr = '0;
  logic [3:0]  tgtChip = '0;
  logic [7:0]  tgtDelay = '0;
  logic [7:0]  curSlot;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [23:0] outAddr;
  logic        remValid;
  logic        remReady = 1'b1;
  logic [31:0] remAddr;
  logic [3:0]  remChip;
  logic [7:0]  remDelay;
  logic        overflowFlag, zeroDelayErr;

  int checks = 0;
  int errors = 0;
  logic [23:0] expLoc[$];
  logic [43:0] expRem[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  aer_fanout_router u0 (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady), .evAddr(evAddr),
    .slotTick(slotTick), .mapWrEn(mapWrEn), .mapIdx(mapIdx), .mapStart(mapStart),
    .mapCount(mapCount), .tgtWrEn(tgtWrEn), .tgtIdx(tgtIdx), .tgtAddr(tgtAddr),
    .tgtChip(tgtChip), .tgtDelay(tgtDelay), .curSlot(curSlot), .outValid(outValid),
    .outReady(outReady), .outAddr(outAddr), .remValid(remValid), .remReady(remReady),
    .remAddr(remAddr), .remChip(remChip), .remDelay(remDelay),
    .overflowFlag(overflowFlag), .zeroDelayErr(zeroDelayErr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare every handshake against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && outReady) begin
        if (expLoc.size() == 0) chk(1'b0, "R6 unexpected local", 64'(outAddr), 64'h0);
        else begin
          logic [23:0] e;
          e = expLoc.pop_front();
          chk(outAddr == e, "R6 local order/value", 64'(outAddr), 64'(e));
        end
      end
      if (remValid && remReady) begin
        if (expRem.size() == 0) chk(1'b0, "R7 unexpected remote", 64'(remAddr), 64'h0);
        else begin
          logic [43:0] e;
          e = expRem.pop_front();
          chk({remAddr, remChip, remDelay} == e, "R7 remote item",
              64'({remAddr, remChip, remDelay}), 64'(e));
        end
      end
    end
  end

  task automatic setMap(input int idx, input int start, input int cnt);
    @(negedge clk);
    mapWrEn = 1'b1; mapIdx = 4'(idx); mapStart = 5'(start); mapCount = 6'(cnt);
    @(negedge clk);
    mapWrEn = 1'b0;
  endtask

  task automatic setTgt(input int idx, input logic [31:0] a, input int chip, input int d);
    @(negedge clk);
    tgtWrEn = 1'b1; tgtIdx = 5'(idx); tgtAddr = a; tgtChip = 4'(chip); tgtDelay = 8'(d);
    @(negedge clk);
    tgtWrEn = 1'b0;
  endtask

  task automatic sendEv(input logic [31:0] a);
    @(negedge clk);
    evValid = 1'b1; evAddr = a;
    while (!evReady) @(negedge clk);
    @(negedge clk);
    evValid = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slotTick = 1'b1;
      @(negedge clk); slotTick = 1'b0;
    end
  endtask

  task automatic settle(); repeat (12) @(negedge clk); endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(curSlot == 0, "R1 slot", 64'(curSlot), 0);
    chk(!outValid && !remValid, "R1 valids", {outValid, remValid}, 0);
    chk(evReady, "R1 evReady", 64'(evReady), 1);
    chk(!overflowFlag && !zeroDelayErr, "R1 flags", {overflowFlag, zeroDelayErr}, 0);

    setTgt(0, 32'h11000001, 0, 0);
    setTgt(1, 32'hAB123456, 0, 2);
    setTgt(2, 32'h22000002, 3, 5);
    setTgt(3, 32'h33000003, 0, 0);
    setTgt(4, 32'h00000A04, 0, 0);
    setTgt(5, 32'h00000A05, 0, 0);
    setTgt(6, 32'h00000A06, 0, 0);
    setTgt(7, 32'hDEADBEEF, 5, 9);
    setTgt(8, 32'h00CAFE08, 0, 0);
    setTgt(9, 32'h00000099, 2, 0);
    setTgt(10, 32'h0000000A, 0, 0);
    for (int i = 0; i < 5; i++) setTgt(11 + i, 32'h100 + i, 0, 3);
    setTgt(16, 32'h00000777, 0, 10);
    setMap(1, 0, 4);
    setMap(2, 4, 3);
    setMap(3, 7, 2);
    setMap(4, 9, 2);
    setMap(5, 11, 5);
    setMap(7, 16, 1);

    // R2 R3 R4: local delay 0 now, remote forwarded, local delay 2 later
    expLoc.push_back(24'h000001);
    expRem.push_back({32'h22000002, 4'd3, 8'd5});
    expLoc.push_back(24'h000003);
    sendEv(32'h11000001);           // folds to index 1
    settle();
    chk(expLoc.size() == 0 && expRem.size() == 0, "R3 split delivered",
        64'(expLoc.size() + expRem.size()), 0);
    tick(1);
    settle();
    chk(!outValid, "R4 not before its slot", 64'(outValid), 0);
    expLoc.push_back(24'h123456);   // R6 truncated to 24 bits
    tick(1);
    settle();
    chk(curSlot == 2, "R5 slot after two ticks", 64'(curSlot), 2);
    chk(expLoc.size() == 0, "R4 delayed item emitted", 64'(expLoc.size()), 0);

    // R6 push and pop on the current slot in the same cycles
    expLoc.push_back(24'h000A04);
    expLoc.push_back(24'h000A05);
    expLoc.push_back(24'h000A06);
    sendEv(32'h00000002);
    settle();
    chk(expLoc.size() == 0, "R6 back-to-back drain", 64'(expLoc.size()), 0);

    // R7 remote stall holds the walk
    remReady = 1'b0;
    sendEv(32'h00000003);
    repeat (4) @(negedge clk);
    chk(remValid && remAddr == 32'hDEADBEEF && remChip == 5 && remDelay == 9,
        "R7 stalled remote", {remValid, remAddr, remChip, remDelay}, {1'b1, 32'hDEADBEEF, 4'd5, 8'd9});
    chk(!evReady, "R2 busy while walking", 64'(evReady), 0);
    chk(!outValid, "R7 later target waits", 64'(outValid), 0);
    expRem.push_back({32'hDEADBEEF, 4'd5, 8'd9});
    expLoc.push_back(24'hCAFE08);
    remReady = 1'b1;
    settle();
    chk(expLoc.size() == 0 && expRem.size() == 0, "R7 release",
        64'(expLoc.size() + expRem.size()), 0);

    // R8 zero-delay remote
    expLoc.push_back(24'h00000A);
    sendEv(32'h00000004);
    settle();
    chk(zeroDelayErr, "R8 error flag", 64'(zeroDelayErr), 1);
    chk(expLoc.size() == 0, "R8 walk continues", 64'(expLoc.size()), 0);

    // R2 count zero source
    sendEv(32'h00000006);
    settle();
    chk(evReady && !outValid && !remValid, "R2 empty source",
        {evReady, outValid, remValid}, 3'b100);

    // R9 overflow: five targets into slot 5, depth four
    sendEv(32'h11000005);           // 1^1^5 = 5
    @(negedge clk);
    chk(!evReady, "R2 evReady low during walk", 64'(evReady), 0);
    settle();
    chk(overflowFlag, "R9 overflow flag", 64'(overflowFlag), 1);
    chk(!outValid, "R4 overflow slot not yet", 64'(outValid), 0);
    for (int i = 0; i < 4; i++) expLoc.push_back(24'h100 + 24'(i));
    tick(3);
    settle();
    chk(expLoc.size() == 0 && !outValid, "R9 four kept, fifth dropped",
        64'(expLoc.size()), 0);

    // R4 R5 wrap: event at slot 145 with delay 10 lands in slot 5
    tick(140);
    chk(curSlot == 145, "R5 slot count", 64'(curSlot), 145);
    sendEv(32'h00000007);
    tick(4);
    chk(curSlot == 149, "R5 top slot", 64'(curSlot), 149);
    tick(1);
    chk(curSlot == 0, "R5 wrap", 64'(curSlot), 0);
    tick(4);
    settle();
    chk(!outValid, "R4 wrap not early", 64'(outValid), 0);
    expLoc.push_back(24'h000777);
    tick(1);
    settle();
    chk(expLoc.size() == 0, "R4 wrapped delivery", 64'(expLoc.size()), 0);

    // R10 rewiring source 1
    setTgt(17, 32'h00515151, 0, 0);
    setMap(1, 17, 1);
    expLoc.push_back(24'h515151);
    sendEv(32'h00000001);
    settle();
    chk(expLoc.size() == 0 && expRem.size() == 0, "R10 rewired",
        64'(expLoc.size() + expRem.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule